// File: doc/BRIEF.md
# DMA Page Translation Unit

This block sits between DMA-capable devices and the system bus. It maps a 24-bit device address onto a 32-bit bus address. The device space is divided into 8 KiB pages. Each page has one 32-bit descriptor in an on-chip table of 2048 entries. Each descriptor supplies:

- the upper physical address bits for its page;
- a two-bit kind code;
- a write-protect flag;
- two attribute flags that travel with the translated address: cache inhibit and full-block transfer;
- two status flags that the block maintains itself: used and modified.

The CPU fills and inspects the table one word at a time through a port addressed by entry index.

A device presents an address, a direction and its own address width. A device narrower than 24 bits is pinned to the top of the device space: every address bit at or above its width is forced to one before the page index is taken. Two clock edges after a request is accepted, a one-cycle response returns one of two results:

- On success, the bus address and its attributes.
- On failure, a fault code, with the address and attributes held at zero.

A successful lookup marks the entry used. A successful write also marks it modified. Both marks are merged into the table one edge after the response. While the CPU port is active, the DMA side is held off.

Top module: `dma_xlate_unit`

## Requirements
- R1: After reset, every entry reads back as zero through the CPU port, so any DMA lookup faults with code 1 (invalid).
- R2: A CPU write (cpu_req=1, cpu_we=1) stores the word at cpu_idx. A CPU read (cpu_req=1, cpu_we=0) returns that word on cpu_rdata, with cpu_rvalid high, one edge later.
- R3: A request accepted at edge E0 gives rsp_valid high for exactly the one cycle after edge E1. On success, rsp_addr is descriptor bits 31..13 followed by device address bits 12..0, rsp_ci equals descriptor bit 6, and rsp_bx equals descriptor bit 5.
- R4: A descriptor whose kind field (bits 1..0) is 00 gives fault code 1 (invalid).
- R5: A kind field of 10 or 11 gives fault code 2 (illegal), even though 11 has its low bit set.
- R6: A write request (dma_write=1) through a valid descriptor whose bit 2 is set gives fault code 3 (protected). A read through the same descriptor succeeds with code 0.
- R7: For dma_width N below 24, device address bits 23..N are forced to one before the page index (bits 23..13) is taken. A width of 24 or more leaves the address unchanged.
- R8: A successful lookup sets the used flag (bit 3) of its entry. The CPU sees the flag from the edge after the response onward.
- R9: A successful write sets the modified flag (bit 4). A read does not set it. A faulting lookup changes no bit of the entry.
- R10: When a CPU write and a status merge hit the same entry on the same edge, the entry holds exactly the CPU word.
- R11: dma_ready is low in every cycle in which cpu_req is high, and no request is accepted in such a cycle.
- R12: On a faulting response, rsp_addr, rsp_ci and rsp_bx are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU table access this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | 11 | Table entry index |
| cpu_wdata | input | 32 | Descriptor word to store |
| cpu_rdata | output | 32 | Descriptor word read |
| cpu_rvalid | output | 1 | cpu_rdata is valid |
| dma_req | input | 1 | Translation request |
| dma_ready | output | 1 | Request can be accepted |
| dma_addr | input | 24 | Device address |
| dma_write | input | 1 | 1 = device writes memory |
| dma_width | input | 5 | Device address width in bits (1..24) |
| rsp_valid | output | 1 | Response strobe |
| rsp_addr | output | 32 | Translated bus address |
| rsp_ci | output | 1 | Cache-inhibit attribute |
| rsp_bx | output | 1 | Full-block attribute |
| rsp_fault | output | 2 | 0 none, 1 invalid, 2 illegal, 3 protected |

## Verification
The bench uses kind code 11 to catch a validity check that looks only at the low bit; such a design would translate through an illegal entry. It sends a write and then a read to a protected page. A design that ignores direction either blocks both or passes both.

The narrow-width cases catch a design that forces the wrong bits and so reaches an entry near the bottom of the table. Read-back of each entry after its lookup catches status merges that are missing, that set the modified flag on a read, or that alter an entry after a fault. A same-edge collision between a CPU write and a status merge shows whether the merge wrongly overrides the CPU word.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

    localparam int VA_W   = 24;
    localparam int PA_W   = 32;
    localparam int PG_SH  = 13;
    localparam int IDX_W  = VA_W - PG_SH;
    localparam int N_ENT  = 1 << IDX_W;
    localparam int PPN_W  = PA_W - PG_SH;
    localparam int WID_W  = $clog2(VA_W + 1);

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_ILLEGAL = 2'd2,
        FLT_WPROT   = 2'd3
    } fault_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [PG_SH-8:0] spare;
        logic             ci;
        logic             bx;
        logic             modf;
        logic             used;
        logic             wp;
        logic [1:0]       kind;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    // Force every address bit at or above the device width to one.
    function automatic logic [VA_W-1:0] pin_to_top(input logic [VA_W-1:0] a,
                                                   input logic [WID_W-1:0] w);
        logic [VA_W-1:0] m;
        if (w >= WID_W'(VA_W))
            m = '0;
        else
            m = ~((VA_W'(1) << w) - VA_W'(1));
        return a | m;
    endfunction

    // Kind must be exactly 01; then write-protect applies to writes only.
    function automatic fault_e judge(input desc_t d, input logic wr);
        if (d.kind == 2'b00)
            return FLT_INVALID;
        else if (d.kind[1])
            return FLT_ILLEGAL;
        else if (wr && d.wp)
            return FLT_WPROT;
        else
            return FLT_NONE;
    endfunction

endpackage

// File: rtl/dxl_table.sv
module dxl_table
    import dxl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    output desc_t            lk_desc,
    input  logic [IDX_W-1:0] cr_idx,
    output desc_t            cr_desc,
    input  logic             cw_en,
    input  logic [IDX_W-1:0] cw_idx,
    input  desc_t            cw_desc,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  desc_t            wb_or
);

    desc_t            mem [N_ENT];
    logic [N_ENT-1:0] vld;
    desc_t            wb_cur;
    logic             wb_go;

    // Entries never written since reset read as zero (kind 00).
    assign lk_desc = vld[lk_idx] ? mem[lk_idx] : '0;
    assign cr_desc = vld[cr_idx] ? mem[cr_idx] : '0;
    assign wb_cur  = vld[wb_idx] ? mem[wb_idx] : '0;

    // Status merge is read-modify-write on the current word; CPU wins ties.
    assign wb_go = wb_en && !(cw_en && (cw_idx == wb_idx));

    always_ff @(posedge clk) begin
        if (wb_go)
            mem[wb_idx] <= desc_t'(wb_cur | wb_or);
        if (cw_en)
            mem[cw_idx] <= cw_desc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            if (wb_go) vld[wb_idx] <= 1'b1;
            if (cw_en) vld[cw_idx] <= 1'b1;
        end
    end

endmodule

// File: rtl/dxl_xlate.sv
module dxl_xlate
    import dxl_pkg::*;
(
    input  desc_t             desc,
    input  logic [PG_SH-1:0]  off,
    input  logic              wr,
    output logic [PA_W-1:0]   pa,
    output logic              ci,
    output logic              bx,
    output fault_e            flt,
    output desc_t             status_or
);

    always_comb begin
        flt       = judge(desc, wr);
        pa        = '0;
        ci        = 1'b0;
        bx        = 1'b0;
        status_or = '0;
        if (flt == FLT_NONE) begin
            pa             = {desc.ppn, off};
            ci             = desc.ci;
            bx             = desc.bx;
            status_or.used = 1'b1;
            status_or.modf = wr;
        end
    end

endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
    import dxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [DESC_W-1:0] cpu_wdata,
    output logic [DESC_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    input  logic              dma_req,
    output logic              dma_ready,
    input  logic [VA_W-1:0]   dma_addr,
    input  logic              dma_write,
    input  logic [WID_W-1:0]  dma_width,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_addr,
    output logic              rsp_ci,
    output logic              rsp_bx,
    output logic [1:0]        rsp_fault
);

    logic             accept;
    logic [VA_W-1:0]  pinned;

    logic             s1_vld;
    logic [IDX_W-1:0] s1_idx;
    logic [PG_SH-1:0] s1_off;
    logic             s1_wr;

    desc_t            lk_desc;
    desc_t            cr_desc;
    logic [PA_W-1:0]  x_pa;
    logic             x_ci;
    logic             x_bx;
    fault_e           x_flt;
    desc_t            x_or;

    logic             wb_en;
    logic [IDX_W-1:0] wb_idx;
    desc_t            wb_or;

    assign dma_ready = !cpu_req;
    assign accept    = dma_req && dma_ready;
    assign pinned    = pin_to_top(dma_addr, dma_width);

    // Stage 1: capture the pinned request.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
            s1_idx <= '0;
            s1_off <= '0;
            s1_wr  <= 1'b0;
        end else begin
            s1_vld <= accept;
            if (accept) begin
                s1_idx <= pinned[VA_W-1:PG_SH];
                s1_off <= pinned[PG_SH-1:0];
                s1_wr  <= dma_write;
            end
        end
    end

    dxl_table u_table (
        .clk     (clk),
        .rst     (rst),
        .lk_idx  (s1_idx),
        .lk_desc (lk_desc),
        .cr_idx  (cpu_idx),
        .cr_desc (cr_desc),
        .cw_en   (cpu_req && cpu_we),
        .cw_idx  (cpu_idx),
        .cw_desc (desc_t'(cpu_wdata)),
        .wb_en   (wb_en),
        .wb_idx  (wb_idx),
        .wb_or   (wb_or)
    );

    dxl_xlate u_xlate (
        .desc      (lk_desc),
        .off       (s1_off),
        .wr        (s1_wr),
        .pa        (x_pa),
        .ci        (x_ci),
        .bx        (x_bx),
        .flt       (x_flt),
        .status_or (x_or)
    );

    // Stage 2: response registers and pending status merge.
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_ci    <= 1'b0;
            rsp_bx    <= 1'b0;
            rsp_fault <= FLT_NONE;
            wb_en     <= 1'b0;
            wb_idx    <= '0;
            wb_or     <= '0;
        end else begin
            rsp_valid <= s1_vld;
            rsp_addr  <= s1_vld ? x_pa : '0;
            rsp_ci    <= s1_vld && x_ci;
            rsp_bx    <= s1_vld && x_bx;
            rsp_fault <= s1_vld ? x_flt : FLT_NONE;
            wb_en     <= s1_vld && (x_flt == FLT_NONE);
            wb_idx    <= s1_idx;
            wb_or     <= x_or;
        end
    end

    // CPU read port.
    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rdata  <= '0;
            cpu_rvalid <= 1'b0;
        end else begin
            cpu_rvalid <= cpu_req && !cpu_we;
            if (cpu_req && !cpu_we)
                cpu_rdata <= cr_desc;
        end
    end

endmodule

// File: rtl/dxl_checker.sv
module dxl_checker
    import dxl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_rvalid,
    input logic              dma_req,
    input logic              dma_ready,
    input logic [VA_W-1:0]   dma_addr,
    input logic              rsp_valid,
    input logic [PA_W-1:0]   rsp_addr,
    input logic              rsp_ci,
    input logic              rsp_bx,
    input logic [1:0]        rsp_fault
);

    assert_stall_R11: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> !dma_ready);

    assert_rsp_after_two_R3: assert property (@(posedge clk) disable iff (rst)
        (dma_req && dma_ready) |=> ##1 rsp_valid);

    assert_rsp_has_cause_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(dma_req && dma_ready, 2));

    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == 2'd0) |->
            rsp_addr[PG_SH-1:0] == $past(dma_addr[PG_SH-1:0], 2));

    assert_fault_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_addr == '0 && !rsp_ci && !rsp_bx));

    assert_cpu_read_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we) |=> cpu_rvalid);

endmodule

bind dma_xlate_unit dxl_checker u_checker (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_rvalid (cpu_rvalid),
    .dma_req    (dma_req),
    .dma_ready  (dma_ready),
    .dma_addr   (dma_addr),
    .rsp_valid  (rsp_valid),
    .rsp_addr   (rsp_addr),
    .rsp_ci     (rsp_ci),
    .rsp_bx     (rsp_bx),
    .rsp_fault  (rsp_fault)
);

// File: tb/dma_xlate_unit_test.sv
module dma_xlate_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [10:0] cpu_idx = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_rvalid;
    logic        dma_req = 1'b0;
    logic        dma_ready;
    logic [23:0] dma_addr = '0;
    logic        dma_write = 1'b0;
    logic [4:0]  dma_width = 5'd24;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic        rsp_ci;
    logic        rsp_bx;
    logic [1:0]  rsp_fault;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dma_xlate_unit uut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_idx(cpu_idx),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .dma_req(dma_req), .dma_ready(dma_ready), .dma_addr(dma_addr),
        .dma_write(dma_write), .dma_width(dma_width),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_ci(rsp_ci),
        .rsp_bx(rsp_bx), .rsp_fault(rsp_fault)
    );

    typedef struct packed {
        logic [31:0] desc;
        logic [23:0] addr;
        logic        wr;
        logic [4:0]  wid;
        logic [1:0]  flt;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'hABCD_E041, 24'h00_2ABC, 1'b0, 5'd24, 2'd0},  // R3 ci
        '{32'h0004_0021, 24'h7F_FFFF, 1'b1, 5'd24, 2'd0},  // R3 bx, R9 write
        '{32'h5000_0000, 24'h12_0010, 1'b0, 5'd24, 2'd1},  // R4
        '{32'h5000_0002, 24'h13_0020, 1'b0, 5'd24, 2'd2},  // R5
        '{32'h5000_0003, 24'h14_0030, 1'b1, 5'd24, 2'd2},  // R5 low bit set
        '{32'h7777_6005, 24'h20_1FFF, 1'b1, 5'd24, 2'd3},  // R6 write refused
        '{32'h7777_6005, 24'h20_1000, 1'b0, 5'd24, 2'd0},  // R6 read allowed
        '{32'h0123_4001, 24'h00_1234, 1'b0, 5'd16, 2'd0},  // R7 16-bit
        '{32'hFFFF_E061, 24'h00_3000, 1'b1, 5'd20, 2'd0},  // R7 20-bit
        '{32'h0000_2001, 24'h00_0000, 1'b0, 5'd13, 2'd0}   // R7 13-bit
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [23:0] top_pin(input logic [23:0] a, input int w);
        logic [23:0] r = a;
        for (int b = 0; b < 24; b++)
            if (b >= w) r[b] = 1'b1;
        return r;
    endfunction

    task automatic cpu_write(input logic [10:0] idx, input logic [31:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_idx = idx; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [10:0] idx, output logic [31:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_idx = idx;
        #1;
        chk("R11 ready low during cpu access", {31'd0, dma_ready}, 32'd0);
        @(negedge clk);
        cpu_req = 1'b0;
        chk("R2 rvalid", {31'd0, cpu_rvalid}, 32'd1);
        d = cpu_rdata;
    endtask

    // Drives one request and samples the response after the second edge.
    task automatic dma_go(input logic [23:0] a, input logic wr, input logic [4:0] w);
        @(negedge clk);
        dma_req = 1'b1; dma_addr = a; dma_write = wr; dma_width = w;
        @(negedge clk);
        dma_req = 1'b0;
        chk("R3 no strobe after one edge", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        chk("R3 strobe after two edges", {31'd0, rsp_valid}, 32'd1);
    endtask

    initial begin
        logic [31:0] rd;
        logic [23:0] pa24;
        logic [10:0] idx;
        logic [31:0] exp_a;
        logic [31:0] exp_d;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        cpu_read(11'd0, rd);
        chk("R1 entry 0 zero", rd, 32'd0);
        cpu_read(11'd2047, rd);
        chk("R1 entry 2047 zero", rd, 32'd0);
        dma_go(24'h45_6789, 1'b0, 5'd24);
        chk("R1 unfilled table faults invalid", {30'd0, rsp_fault}, 32'd1);
        chk("R12 fault addr zero", rsp_addr, 32'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            pa24 = top_pin(VECS[i].addr, int'(VECS[i].wid));
            idx  = pa24[23:13];
            cpu_write(idx, VECS[i].desc);
            dma_go(VECS[i].addr, VECS[i].wr, VECS[i].wid);
            chk($sformatf("R4 R5 R6 R7 fault vec%0d", i), {30'd0, rsp_fault}, {30'd0, VECS[i].flt});
            if (VECS[i].flt == 2'd0) begin
                exp_a = {VECS[i].desc[31:13], pa24[12:0]};
                chk($sformatf("R3 R7 addr vec%0d", i), rsp_addr, exp_a);
                chk($sformatf("R3 ci vec%0d", i), {31'd0, rsp_ci}, {31'd0, VECS[i].desc[6]});
                chk($sformatf("R3 bx vec%0d", i), {31'd0, rsp_bx}, {31'd0, VECS[i].desc[5]});
                exp_d = VECS[i].desc | 32'h8 | (VECS[i].wr ? 32'h10 : 32'h0);
            end else begin
                chk($sformatf("R12 quiet vec%0d", i), {rsp_addr[31:2], rsp_ci, rsp_bx}, 32'd0);
                exp_d = VECS[i].desc;
            end
            @(negedge clk);
            chk($sformatf("R3 one-cycle strobe vec%0d", i), {31'd0, rsp_valid}, 32'd0);
            cpu_read(idx, rd);
            chk($sformatf("R8 R9 status vec%0d", i), rd, exp_d);
        end

        // R10: CPU write and status merge on the same edge, same entry
        cpu_write(11'h055, 32'h0ABC_0001);
        @(negedge clk);
        dma_req = 1'b1; dma_addr = 24'h0A_A000; dma_write = 1'b1; dma_width = 5'd24;
        @(negedge clk);
        dma_req = 1'b0;
        @(negedge clk);
        chk("R10 lookup ok", {30'd0, rsp_fault}, 32'd0);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_idx = 11'h055; cpu_wdata = 32'h0DEF_0041;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        cpu_read(11'h055, rd);
        chk("R10 cpu word wins", rd, 32'h0DEF_0041);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule